// File: doc/BRIEF.md
# Inbound PCI Memory Window Decoder

This block sits on the target side of a PCI bridge and decides whether a memory access started by another bus master falls inside the single window that exposes local memory to the bus. Three programmable values describe that window: a 16-bit mask over the upper address bits [31:16], which sets the window size, a bus-side base address (the memory BAR), and a local base address. When an address hits, the masked upper bits are replaced by the local base, and the low bits pass through unchanged. The result is a local physical address for the memory controller.

Once a burst is claimed, a small state machine follows the data phases. It advances the local address by one word per acknowledged data phase and caps the burst at eight words or at the window's upper edge, whichever comes first. When the cap is reached it signals a disconnect. The same block answers configuration reads and writes of the BAR, which makes standard BAR sizing work. It also carries the satellite-mode response lock and, in host mode, the rule that the bridge ignores configuration cycles it issued itself.

States: `ST_IDLE` (waiting for a strobe), `ST_XFER` (burst claimed, counting words) and `ST_DISC` (one cycle of disconnect). Transitions: `ST_IDLE -> ST_XFER` on a strobe that hits. `ST_XFER -> ST_DISC` when the last allowed word is acknowledged. `ST_XFER -> ST_IDLE` when the initiator ends the burst early. `ST_DISC -> ST_IDLE` always.

Top module: `inb_window`

## Requirements
- R1: After reset `hit` and `disc` are 0, the mask is 0xFFFF, the memory enable is 0, the BAR reads back as 0x00000008, and the response lock equals the `sat_mode` strap.
- R2: A strobe whose command is a memory command (0x6, 0x7, 0xC, 0xE, 0xF) and whose address bits [31:16] AND mask equal the stored BAR bits AND mask raises `hit` in the cycle after the strobe. Any other command, or a mismatch, leaves `hit` at 0.
- R3: Mask 0xFFFF gives a 64 KB window, and each additional cleared low mask bit doubles it, up to 2 GB at 0x8000.
- R4: On a hit, `local_addr` equals the local base in the masked upper bits, the request address elsewhere, and bits [1:0] cleared. It advances by 4 after each `word_ack`.
- R5: No hit occurs unless the memory enable bit (control register bit 1) is set.
- R6: A burst allows at most 8 words. On the acknowledgement of the last allowed word, `disc` is 1 for exactly one cycle with `hit` 0, and the block then returns to idle.
- R7: `burst_limit` is the smaller of 8 and the number of words from the request address up to the last word of the window.
- R8: `req_end` during a burst returns the block to idle with no `disc`. It takes priority over a `word_ack` in the same cycle.
- R9: The BAR reads back as the stored bits [31:16] AND mask, with bits [15:4] zero and bits [3:0] equal to 4'b1000. Writes store only the masked bits, so writing all ones reads back the size.
- R10: While the response lock (control bit 0) is set, no memory access hits. The lock resets to 1 in satellite mode and is cleared by software.
- R11: In host mode (`sat_mode`=0), a configuration cycle (0xA read, 0xB write) with `req_self`=1 is not claimed and leaves the BAR unchanged. Otherwise a configuration write to offset 0x10 (`req_addr[7:2]`=4) loads the BAR from `req_wdata`.
- R12: A register write in the same cycle as a strobe does not affect that strobe's decision. It applies from the next strobe on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sat_mode | input | 1 | Strap: 1 satellite, 0 host |
| req_valid | input | 1 | Address-phase strobe |
| req_cmd | input | 4 | Bus command |
| req_addr | input | 32 | Bus address |
| req_wdata | input | 32 | Configuration write data |
| req_self | input | 1 | Cycle issued by this bridge |
| word_ack | input | 1 | One data word transferred |
| req_end | input | 1 | Initiator ends burst |
| reg_wr_en | input | 1 | Local register write strobe |
| reg_wr_sel | input | 2 | 0 mask [15:0], 1 local base [31:16], 2 control [1:0], 3 BAR [31:16] |
| reg_wr_data | input | 32 | Local register write data |
| hit | output | 1 | Burst claimed (ST_XFER) |
| local_addr | output | 32 | Current local word address |
| burst_limit | output | 4 | Words allowed in this burst |
| disc | output | 1 | Disconnect (ST_DISC) |
| cfg_claim | output | 1 | Configuration cycle accepted |
| cfg_rdata | output | 32 | BAR read-back value |

## Verification
Two things can land in the same clock edge: a local register write and a decode strobe. The bench provokes this by changing the mask, and by clearing the memory enable, in the very cycle the strobe is driven. It then requires that the strobe be judged on the old settings and that the next strobe use the new ones. A second collision, a final `word_ack` arriving together with `req_end`, is judged by requiring a clean return to idle with no disconnect pulse.

// File: rtl/inb_pkg.sv
package inb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_DISC
    } inb_state_e;

    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

    localparam logic [1:0] SEL_MASK  = 2'd0;
    localparam logic [1:0] SEL_LBASE = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_BAR   = 2'd3;

    function automatic logic is_mem_cmd(input logic [3:0] cmd);
        return (cmd == 4'h6) || (cmd == 4'h7) || (cmd == 4'hC) ||
               (cmd == 4'hE) || (cmd == 4'hF);
    endfunction

    function automatic logic is_cfg_cmd(input logic [3:0] cmd);
        return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
    endfunction

endpackage

// File: rtl/inb_regs.sv
module inb_regs
    import inb_pkg::*;
#(
    parameter int MASK_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sat_mode,
    input  logic              sw_wr,
    input  logic [1:0]        sw_sel,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              cfg_wr,
    input  logic [MASK_W-1:0] cfg_bar_hi,
    output logic [MASK_W-1:0] mask,
    output logic [MASK_W-1:0] lbase,
    output logic [MASK_W-1:0] bar_hi,
    output logic              mem_en,
    output logic              resp_lock
);

    localparam int HI_LSB = DATA_W - MASK_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask      <= '1;
            lbase     <= '0;
            bar_hi    <= '0;
            mem_en    <= 1'b0;
            resp_lock <= sat_mode;
        end else if (sw_wr) begin
            unique case (sw_sel)
                SEL_MASK:  mask  <= sw_data[MASK_W-1:0];
                SEL_LBASE: lbase <= sw_data[DATA_W-1:HI_LSB];
                SEL_CTRL: begin
                    mem_en    <= sw_data[1];
                    resp_lock <= sw_data[0];
                end
                SEL_BAR:   bar_hi <= sw_data[DATA_W-1:HI_LSB] & mask;
                default: ;
            endcase
        end else if (cfg_wr) begin
            bar_hi <= cfg_bar_hi & mask;
        end
    end

endmodule

// File: rtl/inb_decode.sv
module inb_decode #(
    parameter int ADDR_W    = 32,
    parameter int MASK_W    = 16,
    parameter int MAX_WORDS = 8,
    parameter int LIM_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] mask,
    input  logic [MASK_W-1:0] lbase,
    input  logic [MASK_W-1:0] bar_hi,
    output logic              match,
    output logic [ADDR_W-1:0] xlat,
    output logic [LIM_W-1:0]  limit
);

    localparam int LO_W   = ADDR_W - MASK_W;
    localparam int WORD_W = ADDR_W - 2;

    logic [ADDR_W-1:0] full_mask;
    logic [ADDR_W-1:0] offset;
    logic [WORD_W-1:0] win_words;
    logic [WORD_W-1:0] off_words;
    logic [WORD_W-1:0] rem_words;

    always_comb begin
        full_mask = {mask, {LO_W{1'b0}}};
        match     = (((addr ^ {bar_hi, {LO_W{1'b0}}}) & full_mask) == '0);
        offset    = addr & ~full_mask;
        xlat      = (offset | ({lbase, {LO_W{1'b0}}} & full_mask))
                    & ~ADDR_W'(3);
        win_words = WORD_W'((~full_mask) >> 2);
        off_words = WORD_W'(offset >> 2);
        rem_words = win_words - off_words;
        if (rem_words >= WORD_W'(MAX_WORDS - 1))
            limit = LIM_W'(MAX_WORDS);
        else
            limit = LIM_W'(rem_words) + LIM_W'(1);
    end

endmodule

// File: rtl/inb_burst_fsm.sv
module inb_burst_fsm
    import inb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_WORDS = 8,
    parameter int LIM_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LIM_W-1:0]  start_limit,
    input  logic              word_ack,
    input  logic              req_end,
    output logic              hit,
    output logic              disc,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LIM_W-1:0]  limit_q
);

    inb_state_e       state_q, state_d;
    logic [LIM_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_XFER;
            ST_XFER: begin
                if (req_end)
                    state_d = ST_IDLE;
                else if (word_ack && left_q == LIM_W'(1))
                    state_d = ST_DISC;
            end
            ST_DISC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            limit_q  <= '0;
            left_q   <= '0;
        end else if (state_q == ST_IDLE && start) begin
            cur_addr <= start_addr;
            limit_q  <= start_limit;
            left_q   <= start_limit;
        end else if (state_q == ST_XFER && word_ack && !req_end) begin
            cur_addr <= cur_addr + ADDR_W'(4);
            left_q   <= left_q - LIM_W'(1);
        end
    end

    always_comb begin
        hit  = (state_q == ST_XFER);
        disc = (state_q == ST_DISC);
    end

    assert_left_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (left_q != '0 && left_q <= limit_q));

    assert_limit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (limit_q >= LIM_W'(1) && limit_q <= LIM_W'(MAX_WORDS)));

    assert_disc_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disc) |-> $past(hit && word_ack && !req_end));

    assert_disc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        disc |=> (!disc && !hit));

    assert_end_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && req_end) |=> (!hit && !disc));

endmodule

// File: rtl/inb_window.sv
module inb_window
    import inb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MASK_W    = 16,
    parameter int MAX_WORDS = 8,
    parameter int LIM_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sat_mode,
    input  logic              req_valid,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_wdata,
    input  logic              req_self,
    input  logic              word_ack,
    input  logic              req_end,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    output logic              hit,
    output logic [ADDR_W-1:0] local_addr,
    output logic [LIM_W-1:0]  burst_limit,
    output logic              disc,
    output logic              cfg_claim,
    output logic [ADDR_W-1:0] cfg_rdata
);

    localparam int          LO_W    = ADDR_W - MASK_W;
    localparam logic [5:0]  BAR_DW  = 6'h04;

    logic [MASK_W-1:0] mask, lbase, bar_hi;
    logic              mem_en, resp_lock;
    logic              match, start, cfg_wr, cfg_ok;
    logic [ADDR_W-1:0] xlat;
    logic [LIM_W-1:0]  limit;
    logic              unused_wdata;

    assign unused_wdata = ^req_wdata[LO_W-1:0];

    assign cfg_ok    = sat_mode || !req_self;
    assign cfg_claim = req_valid && is_cfg_cmd(req_cmd) && cfg_ok;
    assign cfg_wr    = cfg_claim && (req_cmd == CMD_CFG_WR) &&
                       (req_addr[7:2] == BAR_DW);
    assign start     = req_valid && is_mem_cmd(req_cmd) && mem_en &&
                       !resp_lock && match;
    assign cfg_rdata = {bar_hi & mask, {(LO_W-4){1'b0}}, 4'b1000};

    inb_regs #(.MASK_W(MASK_W), .DATA_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sat_mode   (sat_mode),
        .sw_wr      (reg_wr_en),
        .sw_sel     (reg_wr_sel),
        .sw_data    (reg_wr_data),
        .cfg_wr     (cfg_wr),
        .cfg_bar_hi (req_wdata[ADDR_W-1:LO_W]),
        .mask       (mask),
        .lbase      (lbase),
        .bar_hi     (bar_hi),
        .mem_en     (mem_en),
        .resp_lock  (resp_lock)
    );

    inb_decode #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .MAX_WORDS(MAX_WORDS),
                 .LIM_W(LIM_W)) u_dec (
        .addr   (req_addr),
        .mask   (mask),
        .lbase  (lbase),
        .bar_hi (bar_hi),
        .match  (match),
        .xlat   (xlat),
        .limit  (limit)
    );

    inb_burst_fsm #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS),
                    .LIM_W(LIM_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_addr  (xlat),
        .start_limit (limit),
        .word_ack    (word_ack),
        .req_end     (req_end),
        .hit         (hit),
        .disc        (disc),
        .cur_addr    (local_addr),
        .limit_q     (burst_limit)
    );

    assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(mem_en));

    assert_lock_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(!resp_lock));

    assert_xlat_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> (((local_addr[ADDR_W-1:LO_W] ^ $past(lbase)) & $past(mask)) == '0));

    assert_self_cfg_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sat_mode && req_self && !reg_wr_en) |=> $stable(bar_hi));

endmodule

// File: tb/inb_window_bench.sv
module inb_window_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sat_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cmd = 4'h0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_self = 1'b0;
    logic        word_ack = 1'b0;
    logic        req_end = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic        hit, disc, cfg_claim;
    logic [31:0] local_addr, cfg_rdata;
    logic [3:0]  burst_limit;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [15:0] m_mask, m_lbase, m_bar;
    logic        m_en, m_lock;

    always #(CLK_PERIOD/2) clk = ~clk;

    inb_window u_inb_window (
        .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_self(req_self), .word_ack(word_ack),
        .req_end(req_end), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .hit(hit), .local_addr(local_addr),
        .burst_limit(burst_limit), .disc(disc), .cfg_claim(cfg_claim),
        .cfg_rdata(cfg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic f_mem(input logic [3:0] c);
        return c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE || c == 4'hF;
    endfunction

    function automatic logic f_hit(input logic [31:0] a, input logic [3:0] c);
        return f_mem(c) && m_en && !m_lock && ((a[31:16] & m_mask) == (m_bar & m_mask));
    endfunction

    function automatic logic [31:0] f_xlat(input logic [31:0] a);
        return {(m_lbase & m_mask) | (a[31:16] & ~m_mask), a[15:2], 2'b00};
    endfunction

    function automatic logic [3:0] f_limit(input logic [31:0] a);
        longint unsigned last, words;
        last  = {32'h0, a[31:16] | ~m_mask, 16'hFFFF};
        words = ((last - {32'h0, a[31:2], 2'b00}) >> 2) + 1;
        return (words > 8) ? 4'd8 : 4'(words);
    endfunction

    task automatic do_reset(input logic sat);
        @(negedge clk);
        rst_n = 1'b0; sat_mode = sat;
        @(negedge clk);
        rst_n = 1'b1;
        m_mask = 16'hFFFF; m_lbase = '0; m_bar = '0; m_en = 1'b0; m_lock = sat;
    endtask

    task automatic apply_model(input logic [1:0] sel, input logic [31:0] d);
        case (sel)
            2'd0: m_mask = d[15:0];
            2'd1: m_lbase = d[31:16];
            2'd2: begin m_en = d[1]; m_lock = d[0]; end
            default: m_bar = d[31:16] & m_mask;
        endcase
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        apply_model(sel, d);
    endtask

    // Burst: strobe, then n_ack acknowledgements (capped), ended early by req_end if short.
    // With same_wr, a register write is driven in the strobe cycle (R12).
    task automatic access(input logic [31:0] a, input logic [3:0] c, input int n_ack,
                          input bit same_wr, input logic [1:0] wsel, input logic [31:0] wdat,
                          input bit end_with_ack);
        logic eh;
        logic [31:0] ex;
        logic [3:0] el;
        eh = f_hit(a, c); ex = f_xlat(a); el = f_limit(a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c;
        if (same_wr) begin reg_wr_en = 1'b1; reg_wr_sel = wsel; reg_wr_data = wdat; end
        @(negedge clk);
        req_valid = 1'b0; reg_wr_en = 1'b0;
        if (same_wr) apply_model(wsel, wdat);
        check("R2 hit", {31'h0, hit}, {31'h0, eh});
        if (!eh) return;
        check("R4 xlat", local_addr, ex);
        check("R7 limit", {28'h0, burst_limit}, {28'h0, el});
        for (int k = 1; k <= n_ack && k <= int'(el); k++) begin
            word_ack = 1'b1;
            if (end_with_ack && k == n_ack) req_end = 1'b1;
            @(negedge clk);
            word_ack = 1'b0;
            if (req_end) begin
                req_end = 1'b0;
                check("R8 end with ack", {30'h0, hit, disc}, 32'h0);
                return;
            end
            if (k == int'(el)) begin
                check("R6 disc", {30'h0, hit, disc}, 32'h1);
                @(negedge clk);
                check("R6 disc one cycle", {30'h0, hit, disc}, 32'h0);
                return;
            end
            check("R4 advance", local_addr, ex + 32'(4 * k));
        end
        req_end = 1'b1;
        @(negedge clk);
        req_end = 1'b0;
        check("R8 early end", {30'h0, hit, disc}, 32'h0);
    endtask

    task automatic cfg_cycle(input logic [3:0] c, input logic [31:0] a, input logic [31:0] d,
                             input logic self_i, input logic exp_claim);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = d; req_self = self_i;
        #1;
        check("R11 claim", {31'h0, cfg_claim}, {31'h0, exp_claim});
        @(negedge clk);
        req_valid = 1'b0; req_self = 1'b0;
        if (exp_claim && c == 4'hB && a[7:2] == 6'h04) m_bar = d[31:16] & m_mask;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset(1'b0);
        // R1 reset state
        check("R1 hit/disc", {30'h0, hit, disc}, 32'h0);
        check("R1 bar readback", cfg_rdata, 32'h0000_0008);
        // R5 enable off: matching address must not hit
        access(32'h0000_0100, 4'h6, 2, 0, 0, 0, 0);
        sw_write(2'd2, 32'h2);
        // R2 matching memory read, R3 64 KB window edges
        access(32'h0000_0000, 4'h6, 3, 0, 0, 0, 0);
        access(32'h0001_0000, 4'h6, 1, 0, 0, 0, 0);
        // R2 non-memory command ignored
        access(32'h0000_0040, 4'h2, 1, 0, 0, 0, 0);
        // R3 512 MB and 2 GB windows, R4 translation
        sw_write(2'd0, 32'h0000_E000);
        sw_write(2'd1, 32'hA000_0000);
        sw_write(2'd3, 32'h4000_0000);
        access(32'h5FFF_0010, 4'h7, 10, 0, 0, 0, 0);
        access(32'h6000_0000, 4'h7, 1, 0, 0, 0, 0);
        sw_write(2'd0, 32'h0000_8000);
        sw_write(2'd3, 32'h0000_0000);
        access(32'h7FFF_FF00, 4'hC, 9, 0, 0, 0, 0);
        access(32'h8000_0000, 4'hC, 1, 0, 0, 0, 0);
        // R7 boundary cut at 64 KB edge
        sw_write(2'd0, 32'h0000_FFFF);
        sw_write(2'd3, 32'h1234_0000);
        access(32'h1234_FFF4, 4'hE, 8, 0, 0, 0, 0);
        access(32'h1234_FFE0, 4'hF, 8, 0, 0, 0, 0);
        // R8 final ack together with end
        access(32'h1234_0000, 4'h6, 3, 0, 0, 0, 1);
        // R12 mask change in strobe cycle: old mask decides
        access(32'h1235_0000, 4'h6, 1, 1, 2'd0, 32'h0000_FFFE, 0);
        access(32'h1235_0000, 4'h6, 1, 0, 0, 0, 0);
        // R12 enable cleared in strobe cycle, then R5 miss
        access(32'h1234_0000, 4'h6, 2, 1, 2'd2, 32'h0, 0);
        access(32'h1234_0000, 4'h6, 2, 0, 0, 0, 0);
        sw_write(2'd2, 32'h2);
        // R9 sizing readback
        sw_write(2'd0, 32'h0000_FF00);
        sw_write(2'd3, 32'hFFFF_FFFF);
        check("R9 sizing", cfg_rdata, 32'hFF00_0008);
        // R11 host: self config write ignored, foreign one accepted
        cfg_cycle(4'hB, 32'h0000_0010, 32'h3400_0000, 1'b1, 1'b0);
        check("R11 bar unchanged", cfg_rdata, {m_bar & m_mask, 16'h0008});
        cfg_cycle(4'hB, 32'h0000_0010, 32'h3400_0000, 1'b0, 1'b1);
        check("R11 bar written", cfg_rdata, 32'h3400_0008);
        // Random bursts
        for (int i = 0; i < 300; i++) begin
            int k;
            logic [31:0] a;
            if (i % 20 == 0) begin
                k = $urandom_range(0, 15);
                sw_write(2'd0, {16'h0, 16'hFFFF << k});
                sw_write(2'd1, $urandom);
                sw_write(2'd3, $urandom);
            end
            a = $urandom;
            if ($urandom_range(0, 1) == 1)
                a[31:16] = (m_bar & m_mask) | (a[31:16] & ~m_mask);
            access(a, ($urandom_range(0, 3) == 0) ? 4'(
                   $urandom_range(0, 15)) : 4'h7, $urandom_range(1, 10), 0, 0, 0,
                   $urandom_range(0, 4) == 0);
        end
        // R10 satellite lock
        do_reset(1'b1);
        check("R1 sat hit", {31'h0, hit}, 32'h0);
        sw_write(2'd2, 32'h3);
        access(32'h0000_0020, 4'h6, 2, 0, 0, 0, 0);
        cfg_cycle(4'hB, 32'h0000_0010, 32'hFFFF_FFFF, 1'b1, 1'b1);
        check("R9 sat sizing", cfg_rdata, 32'hFFFF_0008);
        cfg_cycle(4'hB, 32'h0000_0010, 32'h0000_0000, 1'b0, 1'b1);
        sw_write(2'd2, 32'h2);
        access(32'h0000_0020, 4'h6, 2, 0, 0, 0, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule